// File: doc/BRIEF.md
# Wishbone Region Address Remapper

This block sits between a Wishbone master port and a Wishbone slave port, both with 32-bit data and 32-bit addresses. It rewrites only the address. The master address is first reduced into a power-of-two origin window. The reduced address is then looked up in a small table of source regions. When it falls inside a region, the region's base is swapped for that entry's destination base and the offset into the region is kept.

Every other bus signal passes straight through: cycle, strobe, write enable, byte select and write data go toward the slave, and acknowledge and read data come back to the master. The path holds no register, so it adds no cycles and keeps transactions in the order the master issues them.

The window and the region table are parameters fixed at elaboration, and all of their values are given in bytes. With word addressing selected, the block divides every window, region and destination value by four. Bus addresses are then word indices. Regions must be powers of two in size and aligned to their size. When regions overlap, the entry with the lowest index takes precedence.

Top module: `wb_region_remap`

## Requirements
- R1: The slave address follows the master address in the same cycle, through combinational logic with no register.
- R2: With word addressing, every window, region and destination value is the byte value divided by 4. For example, master word address 0x1800_4010 yields slave word address 0x0800_0000.
- R3: The master address is reduced modulo the window size (0x2000_0000) relative to the window base (0x0000_0000), so 0x6000_0000 is handled as 0x0000_0000.
- R4: An address in region 0 (source base 0x0000_0000, size 0x1_0000) goes out as 0xF000_0000 plus its offset from the source base.
- R5: An address in region 1 (source base 0x0001_0000, size 64) goes out as 0x8100_0000 plus its offset, so 0x6001_003F becomes 0x8100_003F.
- R6: An address in region 2 (source base 0x0001_0040, size 8) goes out as 0x2000_0000 plus its offset.
- R7: An address that hits no region after the reduction goes out as the reduced address. For example, 0x6002_0000 becomes 0x0002_0000, and 0x0001_0048 is unchanged.
- R8: Cycle, strobe, write enable, byte select and write data reach the slave unchanged. Acknowledge and read data reach the master unchanged.
- R9: When two regions overlap, the entry with the lowest index decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr | input | 32 | Master address |
| m_dat_w | input | 32 | Master write data |
| m_dat_r | output | 32 | Read data returned to the master |
| m_sel | input | 4 | Master byte select |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_ack | output | 1 | Acknowledge returned to the master |
| s_adr | output | 32 | Remapped slave address |
| s_dat_w | output | 32 | Write data to the slave |
| s_dat_r | input | 32 | Slave read data |
| s_sel | output | 4 | Byte select to the slave |
| s_cyc | output | 1 | Cycle to the slave |
| s_stb | output | 1 | Strobe to the slave |
| s_we | output | 1 | Write enable to the slave |
| s_ack | input | 1 | Slave acknowledge |

## Verification
The bench covers several boundary cases:
- The last address of each region and the first address past it. A design with an off-by-one mask would either spill the 64-byte region into the 8-byte one or miss its final byte.
- Addresses above the window. A design that skipped the reduction, or reduced against the wrong size, would send 0x6000_0000 out unchanged instead of remapping it.
- Misses, which must come out as the reduced address and not as the raw master address.
- An overlapping table, which catches a reversed priority because the larger region would win.
- A word-addressed instance, which would expose any constant not scaled by four.

// File: rtl/wb_region_remap.sv
module wb_region_remap #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int N = 3,
  parameter bit WORD_ADDR = 1'b0,
  parameter logic [AW-1:0] WIN_BASE = 32'h0000_0000,
  parameter logic [AW-1:0] WIN_SIZE = 32'h2000_0000,
  parameter logic [N-1:0][AW-1:0] SRC_BASE = {32'h0001_0040, 32'h0001_0000, 32'h0000_0000},
  parameter logic [N-1:0][AW-1:0] SRC_SIZE = {32'h0000_0008, 32'h0000_0040, 32'h0001_0000},
  parameter logic [N-1:0][AW-1:0] DST_BASE = {32'h2000_0000, 32'h8100_0000, 32'hF000_0000}
) (
  input  logic [AW-1:0]   m_adr,
  input  logic [DW-1:0]   m_dat_w,
  output logic [DW-1:0]   m_dat_r,
  input  logic [DW/8-1:0] m_sel,
  input  logic            m_cyc,
  input  logic            m_stb,
  input  logic            m_we,
  output logic            m_ack,
  output logic [AW-1:0]   s_adr,
  output logic [DW-1:0]   s_dat_w,
  input  logic [DW-1:0]   s_dat_r,
  output logic [DW/8-1:0] s_sel,
  output logic            s_cyc,
  output logic            s_stb,
  output logic            s_we,
  input  logic            s_ack
);
  localparam int SH = WORD_ADDR ? 2 : 0;
  localparam logic [AW-1:0] WB = WIN_BASE >> SH;
  localparam logic [AW-1:0] WM = (WIN_SIZE >> SH) - 1'b1;

  logic [AW-1:0] folded;
  logic [N-1:0] hit;
  logic [N-1:0][AW-1:0] cand;

  assign folded = WB + ((m_adr - WB) & WM);

  for (genvar i = 0; i < N; i++) begin : g_region
    localparam logic [AW-1:0] SB = SRC_BASE[i] >> SH;
    localparam logic [AW-1:0] SM = (SRC_SIZE[i] >> SH) - 1'b1;
    localparam logic [AW-1:0] DB = DST_BASE[i] >> SH;
    assign hit[i]  = ((folded ^ SB) & ~SM) == '0;
    assign cand[i] = DB + (folded & SM);
  end

  always_comb begin
    s_adr = folded;
    for (int i = N - 1; i >= 0; i--)
      if (hit[i]) s_adr = cand[i];
  end

  assign s_dat_w = m_dat_w;
  assign s_sel   = m_sel;
  assign s_cyc   = m_cyc;
  assign s_stb   = m_stb;
  assign s_we    = m_we;
  assign m_ack   = s_ack;
  assign m_dat_r = s_dat_r;
endmodule

// File: rtl/wb_region_remap_chk.sv
module wb_region_remap_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int N = 3,
  parameter bit WORD_ADDR = 1'b0,
  parameter logic [AW-1:0] WIN_BASE = 32'h0000_0000,
  parameter logic [AW-1:0] WIN_SIZE = 32'h2000_0000,
  parameter logic [N-1:0][AW-1:0] SRC_BASE = {32'h0001_0040, 32'h0001_0000, 32'h0000_0000},
  parameter logic [N-1:0][AW-1:0] SRC_SIZE = {32'h0000_0008, 32'h0000_0040, 32'h0001_0000},
  parameter logic [N-1:0][AW-1:0] DST_BASE = {32'h2000_0000, 32'h8100_0000, 32'hF000_0000}
) (
  input logic [AW-1:0]   m_adr,
  input logic [DW-1:0]   m_dat_w,
  input logic [DW-1:0]   m_dat_r,
  input logic [DW/8-1:0] m_sel,
  input logic            m_cyc,
  input logic            m_stb,
  input logic            m_we,
  input logic            m_ack,
  input logic [AW-1:0]   s_adr,
  input logic [DW-1:0]   s_dat_w,
  input logic [DW-1:0]   s_dat_r,
  input logic [DW/8-1:0] s_sel,
  input logic            s_cyc,
  input logic            s_stb,
  input logic            s_we,
  input logic            s_ack
);
  localparam int SH = WORD_ADDR ? 2 : 0;
  localparam logic [AW-1:0] WB = WIN_BASE >> SH;
  localparam logic [AW-1:0] WS = WIN_SIZE >> SH;

  logic [AW-1:0] red, expv, sb, sz, db;
  logic any;

  always_comb begin
    red  = WB + ((m_adr - WB) % WS);
    expv = red;
    any  = 1'b0;
    sb = '0; sz = '0; db = '0;
    for (int i = N - 1; i >= 0; i--) begin
      sb = SRC_BASE[i] >> SH;
      sz = SRC_SIZE[i] >> SH;
      db = DST_BASE[i] >> SH;
      if (red >= sb && (red - sb) < sz) begin
        expv = db + (red - sb);
        any  = 1'b1;
      end
    end
    if (any) begin
      p_region_sub_r4: assert (s_adr == expv);
    end else begin
      p_miss_fold_r7: assert (s_adr == red);
      p_in_window_r3: assert ((s_adr - WB) < WS);
    end
    p_fwd_ctl_r8: assert ({s_cyc, s_stb, s_we, s_sel, s_dat_w} == {m_cyc, m_stb, m_we, m_sel, m_dat_w});
    p_ret_ack_r8: assert ({m_ack, m_dat_r} == {s_ack, s_dat_r});
  end
endmodule

bind wb_region_remap wb_region_remap_chk #(
  .AW(AW), .DW(DW), .N(N), .WORD_ADDR(WORD_ADDR),
  .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
  .SRC_BASE(SRC_BASE), .SRC_SIZE(SRC_SIZE), .DST_BASE(DST_BASE)
) u_chk (.*);

// File: tb/tb_wb_region_remap.sv
`timescale 1ns/1ps
module tb_wb_region_remap;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;

  logic [31:0] m_adr, m_dat_w, m_dat_r, s_adr, s_dat_w, s_dat_r;
  logic [3:0]  m_sel, s_sel;
  logic m_cyc, m_stb, m_we, m_ack, s_cyc, s_stb, s_we, s_ack;

  wb_region_remap dut (.*);

  logic [31:0] w_adr, w_sadr, w_dr, w_sdw;
  logic [3:0]  w_ssel;
  logic w_ack, w_cyc, w_stb, w_we;
  wb_region_remap #(.WORD_ADDR(1'b1)) dut_w (
    .m_adr(w_adr), .m_dat_w(32'h0), .m_dat_r(w_dr), .m_sel(4'h0), .m_cyc(1'b0),
    .m_stb(1'b0), .m_we(1'b0), .m_ack(w_ack), .s_adr(w_sadr), .s_dat_w(w_sdw),
    .s_dat_r(32'h0), .s_sel(w_ssel), .s_cyc(w_cyc), .s_stb(w_stb), .s_we(w_we), .s_ack(1'b0));

  logic [31:0] o_adr, o_sadr, o_dr, o_sdw;
  logic [3:0]  o_ssel;
  logic o_ack, o_cyc, o_stb, o_we;
  wb_region_remap #(.N(2),
    .SRC_BASE({32'h0000_1000, 32'h0000_1000}),
    .SRC_SIZE({32'h0000_1000, 32'h0000_0100}),
    .DST_BASE({32'hB000_0000, 32'hA000_0000})) dut_o (
    .m_adr(o_adr), .m_dat_w(32'h0), .m_dat_r(o_dr), .m_sel(4'h0), .m_cyc(1'b0),
    .m_stb(1'b0), .m_we(1'b0), .m_ack(o_ack), .s_adr(o_sadr), .s_dat_w(o_sdw),
    .s_dat_r(32'h0), .s_sel(o_ssel), .s_cyc(o_cyc), .s_stb(o_stb), .s_we(o_we), .s_ack(1'b0));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_b(input logic [31:0] a);
    @(negedge clk);
    m_adr = a;
    #1;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    m_adr = '0; m_dat_w = '0; m_sel = '0; m_cyc = 0; m_stb = 0; m_we = 0;
    s_dat_r = '0; s_ack = 0; w_adr = '0; o_adr = '0;
    #1;
    check("R8 idle strobe", {31'b0, s_stb}, 32'h0);
    check("R8 idle ack", {31'b0, m_ack}, 32'h0);
    check("R4 idle addr", s_adr, 32'hF000_0000);
  endtask

  task automatic t_sequence;
    m_cyc = 1; m_stb = 1; m_we = 1;
    drive_b(32'h6000_0000); check("R3 R4 fold to region0", s_adr, 32'hF000_0000);
    drive_b(32'h6001_0000); check("R5 region1 base", s_adr, 32'h8100_0000);
    drive_b(32'h6001_0040); check("R6 region2 base", s_adr, 32'h2000_0000);
  endtask

  task automatic t_offsets;
    drive_b(32'h0000_1234); check("R4 offset", s_adr, 32'hF000_1234);
    drive_b(32'h2000_FFFC); check("R4 last word fold", s_adr, 32'hF000_FFFC);
    drive_b(32'hE001_003F); check("R5 last byte", s_adr, 32'h8100_003F);
    drive_b(32'h0001_0047); check("R6 last byte", s_adr, 32'h2000_0007);
  endtask

  task automatic t_miss;
    drive_b(32'h0001_0048); check("R7 past region2", s_adr, 32'h0001_0048);
    drive_b(32'h6002_0000); check("R7 folded miss", s_adr, 32'h0002_0000);
    drive_b(32'hFFFF_FFFC); check("R7 R3 top fold", s_adr, 32'h1FFF_FFFC);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    m_adr = 32'h4001_0004;
    #1;
    check("R1 no latency", s_adr, 32'h8100_0004);
    m_adr = 32'h0001_0041;
    #1;
    check("R1 follows at once", s_adr, 32'h2000_0001);
  endtask

  task automatic t_passthrough;
    @(negedge clk);
    m_dat_w = 32'hA5C3_0F1E; m_sel = 4'b1010; m_we = 0; m_cyc = 1; m_stb = 1;
    s_ack = 1; s_dat_r = 32'h1357_9BDF;
    #1;
    check("R8 write data", s_dat_w, 32'hA5C3_0F1E);
    check("R8 sel/cyc/stb/we", {24'b0, s_sel, s_cyc, s_stb, s_we, 1'b0}, {24'b0, 4'b1010, 1'b1, 1'b1, 1'b0, 1'b0});
    check("R8 ack", {31'b0, m_ack}, 32'h1);
    check("R8 read data", m_dat_r, 32'h1357_9BDF);
    @(negedge clk);
    s_ack = 0; m_stb = 0; m_cyc = 0;
    #1;
    check("R8 ack drop", {30'b0, m_ack, s_stb}, 32'h0);
  endtask

  task automatic t_word;
    @(negedge clk);
    w_adr = 32'h1800_4010;
    #1;
    check("R2 word region2", w_sadr, 32'h0800_0000);
    w_adr = 32'h1800_0001;
    #1;
    check("R2 word region0", w_sadr, 32'h3C00_0001);
    w_adr = 32'h1800_4000;
    #1;
    check("R2 word region1", w_sadr, 32'h2040_0000);
    w_adr = 32'h0800_0000;
    #1;
    check("R2 word fold", w_sadr, 32'h3C00_0000);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    o_adr = 32'h0000_1010;
    #1;
    check("R9 low index wins", o_sadr, 32'hA000_0010);
    o_adr = 32'h0000_1200;
    #1;
    check("R9 outer region", o_sadr, 32'hB000_0200);
  endtask

  initial begin
    t_reset_state();
    t_sequence();
    t_offsets();
    t_miss();
    t_same_cycle();
    t_passthrough();
    t_word();
    t_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule